// File: doc/BRIEF.md
# Touch-Pen Debounce and Interrupt Unit

This unit sits between the raw pen-down detect line of a resistive touch panel and the interrupt system. It synchronizes the detect line and filters it with a programmable debounce counter. It then reports a clean touch state and raises a one-cycle interrupt request when a touch qualifies. It also holds the static panel-switch and pull-down enables, which it drives straight out to the analog front end.

Two 8-bit registers sit behind a simple synchronous write port and a combinational read port. Address 0 is the control register and address 1 is the debounce register. The debounce length is the sum of the weights of the set bits, N, turned into an interval of L = N*64-16 clocks. No port of this block carries a data stream, so every pin is a plain level or strobe and there is no back-pressure to manage. A low-power input freezes the filter, the way the debounce clock is gated in idle and stop states.

Top module: `pen_debounce_top`

## Requirements
- R1: After reset, both registers read 0x00, `touch` and `touch_irq` are 0, and `sw_en` and `pull_xp` are 0.
- R2: Control register (address 0) fields:
  - bit7 is the interface enable and bit6 is the X+ pull-down enable, driven on `pull_xp`.
  - bit5 is read-only: it reads the filtered touch state, and writes to it are ignored.
  - bit4 is the interrupt enable.
  - bits3..0 are the switch enables (bit3 Y+, bit2 X+, bit1 Y-, bit0 X-). They appear on `sw_en` with the same bit order from the clock edge that performs the write.
- R3: Debounce register (address 1) fields:
  - bit7 enables debouncing.
  - bits6..0 carry weights 1024, 256, 64, 8, 4, 2, 1 (bit6 down to bit0).
  - All eight bits read back as written.
- R4: With debouncing enabled and N>0, `touch` rises L+3 clock edges after `pen_raw` rises and stays high, where L = N*64-16. Example: 0x95 gives N=69 and L=4400.
- R5: With debouncing enabled and N=0, the interval is treated as zero and `touch` rises 3 edges after `pen_raw` rises.
- R6: If the synchronized detect drops before the interval completes, the count restarts from zero, and neither `touch` nor `touch_irq` is asserted.
- R7: With debouncing disabled, `touch` follows the synchronized input and rises 3 edges after `pen_raw`, whatever the weight bits are. The interrupt comes on that rising edge.
- R8: `touch_irq` is a single-cycle pulse in the same cycle that `touch` rises. It fires only when the interface enable and the interrupt enable are both set.
- R9: While `low_power` is high, the counter and `touch` hold their values and `touch_irq` stays 0. If `pen_raw` stayed high throughout, `touch` rises L+1 edges after `low_power` falls.
- R10: The interval is captured while no touch is active. A debounce write made during a count takes effect from the next touch.
- R11: `touch` falls 3 edges after `pen_raw` falls, with or without debouncing.
- R12: With the interface enable clear, `touch` stays 0 and no interrupt is raised whatever `pen_raw` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write address: 0 control, 1 debounce |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 1 | Read address: 0 control, 1 debounce |
| reg_rdata | output | 8 | Read data, combinational |
| pen_raw | input | 1 | Asynchronous raw pen-down detect |
| low_power | input | 1 | High while the debounce clock would be stopped |
| touch | output | 1 | Filtered touch state |
| touch_irq | output | 1 | One-cycle touch interrupt request |
| pull_xp | output | 1 | X+ pull-down enable |
| sw_en | output | 4 | Panel switch enables {Y+, X+, Y-, X-} |

## Verification
The assertions take it that `reg_wr` and `low_power` are low during reset and change only as synchronous inputs. `pen_raw` may change at any time, because it passes through the synchronizer before any checked state sees it. The stimulus drives every input on the falling clock edge and holds the detect line high long enough for each interval to complete. Debounce settings are drawn so that the longest interval stays within a few thousand cycles, apart from one directed case. Bounce bursts are kept shorter than the active interval, so restart behaviour is observed rather than a qualified touch.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned NUM_WT = 7;

  typedef struct packed {
    logic       if_en;
    logic       pd_en;
    logic       stat;
    logic       int_en;
    logic [3:0] sw;
  } ctrl_t;

  typedef struct packed {
    logic              dbc_en;
    logic [NUM_WT-1:0] wt;
  } dbc_t;

  function automatic int unsigned bit_weight(input int unsigned idx);
    case (idx)
      6:       return 1024;
      5:       return 256;
      4:       return 64;
      3:       return 8;
      2:       return 4;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned weight_sum(input logic [NUM_WT-1:0] w);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < NUM_WT; i++) begin
      if (w[i]) acc = acc + bit_weight(i);
    end
    return acc;
  endfunction
endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pdb_regs.sv
module pdb_regs
  import pdb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             waddr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output dbc_t             dbc
);
  ctrl_t ctrl_q;
  dbc_t  dbc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dbc_q  <= '0;
    end else if (wr) begin
      if (waddr == 1'b0) begin
        ctrl_q        <= ctrl_t'(wdata);
        ctrl_q.stat   <= 1'b0;
      end else begin
        dbc_q <= dbc_t'(wdata);
      end
    end
  end

  assign ctrl = ctrl_q;
  assign dbc  = dbc_q;

  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> ($stable(ctrl_q) && $stable(dbc_q)));
  p_stat_unstored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr) |-> (ctrl_q.stat == 1'b0));
endmodule

// File: rtl/pdb_interval.sv
module pdb_interval
  import pdb_pkg::*;
#(
  parameter int unsigned MUL   = 64,
  parameter int unsigned OFS   = 16,
  parameter int unsigned CNT_W = 17
) (
  input  logic [NUM_WT-1:0] wt,
  output logic [CNT_W-1:0]  lim
);
  logic [31:0] n_sum;
  logic [31:0] scaled;

  always_comb begin
    n_sum  = weight_sum(wt);
    scaled = n_sum * MUL;
    if (scaled > OFS) lim = CNT_W'(scaled - OFS);
    else              lim = '0;
  end
endmodule

// File: rtl/pdb_filter.sv
module pdb_filter #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pen_s,
  input  logic             if_en,
  input  logic             int_en,
  input  logic             dbc_en,
  input  logic             low_power,
  input  logic [CNT_W-1:0] lim_in,
  output logic             status,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             filt_q;
  logic             irq_q;
  logic             active;
  logic             done;
  logic             rise;

  assign active = if_en & pen_s;
  assign done   = !dbc_en || (cnt_q >= lim_q);
  assign rise   = active && !filt_q && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      filt_q <= 1'b0;
    end else if (!low_power) begin
      if (!active) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
        lim_q  <= lim_in;
      end else if (!filt_q) begin
        if (done) filt_q <= 1'b1;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= rise && !low_power && int_en && if_en;
  end

  assign status = filt_q;
  assign irq    = irq_q;

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(if_en && int_en));
  p_irq_with_touch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $rose(filt_q));
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(low_power) |-> ($stable(cnt_q) && $stable(filt_q)));
  p_no_irq_lp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(low_power) |-> !irq_q);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
  p_touch_needs_pen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q && !$past(low_power)) |-> $past(pen_s && if_en));
  p_rise_after_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(filt_q) && $past(dbc_en)) |-> $past(cnt_q >= lim_q));
  p_lim_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) |-> $stable(lim_q));
endmodule

// File: rtl/pen_debounce_top.sv
module pen_debounce_top
  import pdb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_MUL    = 64,
  parameter int unsigned TICK_OFS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_waddr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_raddr,
  output logic [7:0] reg_rdata,
  input  logic       pen_raw,
  input  logic       low_power,
  output logic       touch,
  output logic       touch_irq,
  output logic       pull_xp,
  output logic [3:0] sw_en
);
  localparam int unsigned MAX_N   = weight_sum('1);
  localparam int unsigned MAX_LIM = MAX_N * TICK_MUL;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

  ctrl_t            ctrl;
  dbc_t             dbc;
  logic             pen_s;
  logic [CNT_W-1:0] lim;
  logic             status;

  pdb_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .dbc   (dbc)
  );

  pdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pen_raw),
    .dout  (pen_s)
  );

  pdb_interval #(.MUL(TICK_MUL), .OFS(TICK_OFS), .CNT_W(CNT_W)) u_intv (
    .wt  (dbc.wt),
    .lim (lim)
  );

  pdb_filter #(.CNT_W(CNT_W)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pen_s     (pen_s),
    .if_en     (ctrl.if_en),
    .int_en    (ctrl.int_en),
    .dbc_en    (dbc.dbc_en),
    .low_power (low_power),
    .lim_in    (lim),
    .status    (status),
    .irq       (touch_irq)
  );

  always_comb begin
    if (reg_raddr == 1'b0) reg_rdata = {ctrl.if_en, ctrl.pd_en, status, ctrl.int_en, ctrl.sw};
    else                   reg_rdata = dbc;
  end

  genvar s;
  generate
    for (s = 0; s < 4; s++) begin : g_sw
      assign sw_en[s] = ctrl.sw[s];
    end
  endgenerate

  assign pull_xp = ctrl.pd_en;
  assign touch   = status;

  p_touch_off_when_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ctrl.if_en) && !$past(low_power)) |-> !touch);
  p_switch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && !$past(reg_waddr)) |-> (sw_en == $past(reg_wdata[3:0])));
endmodule

// File: tb/tb_pen_debounce_top.sv
module tb_pen_debounce_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_waddr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_raddr = 1'b0;
  logic [7:0] reg_rdata;
  logic       pen_raw = 1'b0;
  logic       low_power = 1'b0;
  logic       touch;
  logic       touch_irq;
  logic       pull_xp;
  logic [3:0] sw_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pen_debounce_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pen_raw(pen_raw), .low_power(low_power), .touch(touch),
    .touch_irq(touch_irq), .pull_xp(pull_xp), .sw_en(sw_en)
  );

  function automatic int exp_lim(input logic [7:0] d);
    int w[7] = '{1, 2, 4, 8, 64, 256, 1024};
    int n = 0;
    for (int i = 0; i < 7; i++) if (d[i]) n += w[i];
    return (n == 0) ? 0 : n * 64 - 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_raddr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise pen_raw and count edges until touch; optional register write mid-count.
  task automatic measure(input int limit, input int wr_at, input logic [7:0] wval,
                         output int lat, output int irqs);
    lat = -1; irqs = 0;
    @(negedge clk);
    pen_raw = 1'b1;
    for (int n = 1; n <= limit; n++) begin
      if (wr_at > 0 && n == wr_at) begin
        reg_wr = 1'b1; reg_waddr = 1'b1; reg_wdata = wval;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
      if (touch_irq) irqs++;
      if (touch) begin lat = n; break; end
    end
    reg_wr = 1'b0;
  endtask

  task automatic release_pen(input string tag);
    pen_raw = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(touch == 1'b1, tag, touch, 1);
    @(negedge clk);
    chk(touch == 1'b0, tag, touch, 0);
    idle(4);
  endtask

  task automatic touch_case(input logic [7:0] d, input string tag);
    int lat, irqs, e;
    wr(1'b1, d);
    idle(3);
    e = d[7] ? exp_lim(d) + 3 : 3;
    measure(e + 20, 0, 8'h00, lat, irqs);
    chk(lat == e, tag, lat, e);
    chk(irqs == 1, {tag, "_irq"}, irqs, 1);
    release_pen("R11");
  endtask

  initial begin
    logic [7:0] v;
    int lat, irqs, seed;
    seed = $urandom(32'h5eed);
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(1'b0, v); chk(v == 8'h00, "R1", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1", v, 0);
    chk(touch == 0 && touch_irq == 0, "R1", {touch, touch_irq}, 0);
    chk(sw_en == 0 && pull_xp == 0, "R1", {pull_xp, sw_en}, 0);

    // R2 control register, bit5 read-only
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk(v == 8'hDF, "R2", v, 8'hDF);
    chk(sw_en == 4'hF && pull_xp == 1, "R2", {pull_xp, sw_en}, 8'h1F);
    wr(1'b0, 8'h95);
    chk(sw_en == 4'h5 && pull_xp == 0, "R2", {pull_xp, sw_en}, 5);

    // R3 debounce readback
    wr(1'b1, 8'h95);
    rd(1'b1, v); chk(v == 8'h95, "R3", v, 8'h95);

    // R12 interface disabled
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h80);
    idle(2);
    pen_raw = 1'b1;
    irqs = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (touch || touch_irq) irqs++; end
    chk(irqs == 0, "R12", irqs, 0);
    rd(1'b0, v); chk(v[5] == 1'b0, "R12", v[5], 0);
    pen_raw = 1'b0; idle(4);

    // enable interface and interrupt for the main tests
    wr(1'b0, 8'h90);
    touch_case(8'h95, "R4");
    touch_case(8'h80, "R5");
    touch_case(8'h7F, "R7");
    touch_case(8'h00, "R7");

    // R2 status bit reads the touch state
    wr(1'b1, 8'h80); idle(3);
    measure(20, 0, 8'h00, lat, irqs);
    rd(1'b0, v); chk(v[5] == 1'b1, "R2", v[5], 1);
    release_pen("R11");

    // R6 bounce restarts the count
    wr(1'b1, 8'h81); idle(3);
    irqs = 0;
    for (int b = 0; b < 3; b++) begin
      pen_raw = 1'b1;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (touch || touch_irq) irqs++; end
      pen_raw = 1'b0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (touch || touch_irq) irqs++; end
    end
    chk(irqs == 0, "R6", irqs, 0);
    measure(100, 0, 8'h00, lat, irqs);
    chk(lat == exp_lim(8'h81) + 3, "R6", lat, exp_lim(8'h81) + 3);
    release_pen("R11");

    // R8 interrupt enable clear: touch without irq
    wr(1'b0, 8'h80);
    measure(100, 0, 8'h00, lat, irqs);
    chk(lat == 51 && irqs == 0, "R8", irqs, 0);
    release_pen("R11");
    wr(1'b0, 8'h90);

    // R9 low power freezes
    @(negedge clk); low_power = 1'b1;
    pen_raw = 1'b1;
    irqs = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (touch || touch_irq) irqs++; end
    chk(irqs == 0, "R9", irqs, 0);
    low_power = 1'b0;
    lat = -1; irqs = 0;
    for (int n = 1; n <= 100; n++) begin
      @(negedge clk);
      if (touch_irq) irqs++;
      if (touch) begin lat = n; break; end
    end
    chk(lat == exp_lim(8'h81) + 1, "R9", lat, exp_lim(8'h81) + 1);
    chk(irqs == 1, "R9", irqs, 1);
    release_pen("R11");

    // R10 write during a count applies to the next touch
    measure(200, 10, 8'h82, lat, irqs);
    chk(lat == exp_lim(8'h81) + 3, "R10", lat, exp_lim(8'h81) + 3);
    release_pen("R11");
    measure(200, 0, 8'h00, lat, irqs);
    chk(lat == exp_lim(8'h82) + 3, "R10", lat, exp_lim(8'h82) + 3);
    release_pen("R11");

    // R4 random intervals
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'h80 | 8'($urandom() & 32'h1F);
      touch_case(d, "R4");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule